// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host side of a small serial analog-to-digital converter link. It drives three wires: a start strobe and a serial clock going out, and a data line coming back. One accepted request runs one complete cycle. The block encodes the wanted input or polarity on the strobe, holds the strobe high for the acquisition window, and drops it to take the sample. It then waits out the conversion time, clocks the whole output frame in, and delivers the 10-bit code.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole cycle, so the requester must keep `req_valid` and `req_mode` steady until it sees ready. The result side has no back-pressure. `res_valid` is high for exactly one cycle, and the result fields hold their values until the next result. All analog-facing intervals are given in nanoseconds together with the system clock period. They are turned into whole cycles by rounding up, so no minimum is ever cut short.

Top module: `adc_read_seq`

## Requirements
- R1: After reset and between cycles, `cnv_o` and `sclk_o` are low and `req_ready` is high, with `busy_o` low.
- R2: With `req_mode`=0 (first input / unipolar), `cnv_o` rises exactly once per cycle and stays high for at least the acquisition count before it falls to sample.
- R3: With `req_mode`=1 (second input / bipolar), `cnv_o` goes high for at least the strobe-phase count, then low for at least that count, then high again for the acquisition count before it falls to sample.
- R4: No serial clock edge occurs until at least the conversion count of cycles after the sampling fall of `cnv_o`.
- R5: `sclk_o` idles low. Each high phase lasts at least the high count and each low phase at least the low count. A cycle has exactly 12 rising edges, or 16 when `LONG_READ`=1.
- R6: `sdata_i` is captured on each rising edge of `sclk_o`, MSB first. `res_data` holds the first 10 captured bits. The two sub-bits after them and any further bits have no effect on the result.
- R7: `res_twos` equals the mode of the request. When it is 1, `res_sext` is `res_data` sign-extended from bit 9; when it is 0, `res_sext` is `res_data` zero-extended.
- R8: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until after the result pulse. A `req_valid` raised while not ready produces no cycle.
- R9: `res_valid` is a one-cycle pulse at the end of each cycle, and `cnv_o` and `sclk_o` are both low during it.
- R10: Each interval is the ceiling of its nanosecond value divided by `CLK_NS`. With the defaults this gives a strobe phase of 4 cycles, acquisition of 175, conversion of 463, and clock high and low phases of 8 each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_mode | input | 1 | 0: first input or unipolar; 1: second input or bipolar |
| busy_o | output | 1 | A cycle is in progress |
| cnv_o | output | 1 | Conversion start strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdata_i | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle result pulse |
| res_data | output | 10 | Captured result code |
| res_twos | output | 1 | Result is two's complement |
| res_sext | output | SEXT_W | Result extended to SEXT_W bits |

## Verification
The bench builds two copies side by side on an 8 ns clock. One uses the 12-clock read and the other sets `LONG_READ`=1, so both frame lengths run on the same stimulus and the padding bits reach the capture path. The 63 ns clock phases and the 3.7 µs conversion time do not divide evenly by 8 ns, so a sequencer that truncated instead of rounding up would fall one cycle short of a converter model that measures every phase. Codes at both rails and at the sign boundary bring the extension logic into reach in both modes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD_HI,
    ST_LEAD_LO,
    ST_TRACK,
    ST_CONVERT,
    ST_READ,
    ST_DONE
  } seq_state_t;

  // Whole cycles covering at least ns nanoseconds; never zero.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R10: an armed interval runs down one count per cycle
  assert_timer_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
  parameter int unsigned HI_CYC = 8,
  parameter int unsigned LO_CYC = 8,
  parameter int unsigned NCLK   = 12,
  parameter int unsigned KEEP   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            sdata_i,
  output logic            sclk_o,
  output logic            done_o,
  output logic [KEEP-1:0] word_o
);
  localparam int unsigned PMAX = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int unsigned PW   = $clog2(PMAX + 1);
  localparam int unsigned BW   = $clog2(NCLK + 1);

  logic          active;
  logic          sclk_q;
  logic [PW-1:0] ph;
  logic [BW-1:0] nbit;
  logic [KEEP-1:0] word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sclk_q <= 1'b0;
      ph     <= '0;
      nbit   <= '0;
      word   <= '0;
    end else if (start) begin
      active <= 1'b1;
      sclk_q <= 1'b1;
      ph     <= PW'(HI_CYC - 1);
      nbit   <= BW'(1);
      word   <= {word[KEEP-2:0], sdata_i};
    end else if (active) begin
      if (ph != '0) begin
        ph <= ph - 1'b1;
      end else if (sclk_q) begin
        sclk_q <= 1'b0;
        ph     <= PW'(LO_CYC - 1);
      end else if (nbit == BW'(NCLK)) begin
        active <= 1'b0;
      end else begin
        sclk_q <= 1'b1;
        ph     <= PW'(HI_CYC - 1);
        nbit   <= nbit + 1'b1;
        if (nbit < BW'(KEEP)) word <= {word[KEEP-2:0], sdata_i};
      end
    end
  end

  assign sclk_o = sclk_q;
  assign word_o = word;
  assign done_o = active && (ph == '0) && !sclk_q && (nbit == BW'(NCLK));

  // R5: the serial clock only toggles while a read is running
  assert_sclk_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> active);
  // R5: never more rising edges than the configured frame
  assert_edge_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nbit <= BW'(NCLK));

endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned CLK_NS     = 8,
  parameter int unsigned STROBE_NS  = 30,
  parameter int unsigned ACQ_NS     = 1400,
  parameter int unsigned CONV_NS    = 3700,
  parameter int unsigned SCLK_HI_NS = 63,
  parameter int unsigned SCLK_LO_NS = 63,
  parameter bit          LONG_READ  = 1'b0,
  parameter int unsigned RES_W      = 10,
  parameter int unsigned SUB_W      = 2,
  parameter int unsigned SEXT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_mode,
  output logic              busy_o,
  output logic              cnv_o,
  output logic              sclk_o,
  input  logic              sdata_i,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic              res_twos,
  output logic [SEXT_W-1:0] res_sext
);
  localparam int unsigned PH_CYC   = ns_to_cyc(STROBE_NS, CLK_NS);
  localparam int unsigned ACQ_CYC  = ns_to_cyc(ACQ_NS, CLK_NS);
  localparam int unsigned CONV_CYC = ns_to_cyc(CONV_NS, CLK_NS);
  localparam int unsigned HI_CYC   = ns_to_cyc(SCLK_HI_NS, CLK_NS);
  localparam int unsigned LO_CYC   = ns_to_cyc(SCLK_LO_NS, CLK_NS);
  localparam int unsigned FRAME    = RES_W + SUB_W;
  localparam int unsigned NCLK     = LONG_READ ? ((FRAME + 7) / 8) * 8 : FRAME;
  localparam int unsigned TMAX     = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
  localparam int unsigned TW       = $clog2(TMAX + 1);

  seq_state_t st, st_nxt;
  logic          mode_q;
  logic          t_load, t_exp;
  logic [TW-1:0] t_val;
  logic          rd_start, rd_done;
  logic [FRAME-1:0] rd_word;
  logic [RES_W-1:0] code;
  logic [SEXT_W-1:0] code_ext;

  adc_seq_timer #(.W(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  adc_seq_shift #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC), .NCLK(NCLK), .KEEP(FRAME)) shift_i (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .sdata_i(sdata_i),
    .sclk_o(sclk_o), .done_o(rd_done), .word_o(rd_word)
  );

  always_comb begin
    st_nxt   = st;
    t_load   = 1'b0;
    t_val    = '0;
    rd_start = 1'b0;
    unique case (st)
      ST_IDLE: if (req_valid) begin
        t_load = 1'b1;
        if (req_mode) begin
          st_nxt = ST_LEAD_HI;
          t_val  = TW'(PH_CYC - 1);
        end else begin
          st_nxt = ST_TRACK;
          t_val  = TW'(ACQ_CYC - 1);
        end
      end
      ST_LEAD_HI: if (t_exp) begin
        st_nxt = ST_LEAD_LO;
        t_load = 1'b1;
        t_val  = TW'(PH_CYC - 1);
      end
      ST_LEAD_LO: if (t_exp) begin
        st_nxt = ST_TRACK;
        t_load = 1'b1;
        t_val  = TW'(ACQ_CYC - 1);
      end
      ST_TRACK: if (t_exp) begin
        st_nxt = ST_CONVERT;
        t_load = 1'b1;
        t_val  = TW'(CONV_CYC - 1);
      end
      ST_CONVERT: if (t_exp) begin
        st_nxt   = ST_READ;
        rd_start = 1'b1;
      end
      ST_READ: if (rd_done) st_nxt = ST_DONE;
      ST_DONE: st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign code = rd_word[FRAME-1:SUB_W];

  generate
    if (SEXT_W > RES_W) begin : g_ext
      assign code_ext = mode_q ? {{(SEXT_W-RES_W){code[RES_W-1]}}, code}
                               : {{(SEXT_W-RES_W){1'b0}}, code};
    end else begin : g_noext
      assign code_ext = code[SEXT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      mode_q    <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_twos  <= 1'b0;
      res_sext  <= '0;
    end else begin
      st        <= st_nxt;
      res_valid <= 1'b0;
      if (st == ST_IDLE && req_valid) mode_q <= req_mode;
      if (st == ST_READ && rd_done) begin
        res_valid <= 1'b1;
        res_data  <= code;
        res_twos  <= mode_q;
        res_sext  <= code_ext;
      end
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign busy_o    = !req_ready;
  assign cnv_o     = (st == ST_LEAD_HI) || (st == ST_TRACK);

  // R9: result strobe lasts a single cycle
  assert_one_cycle_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R9: converter lines are quiet while the result is presented
  assert_quiet_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!cnv_o && !sclk_o));
  // R8: no new request is taken while the result is still out
  assert_holdoff_at_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);
  // R8: an accepted request drops ready on the next cycle
  assert_accept_drops_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R4: serial clock never overlaps the start strobe
  assert_no_clock_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> !sclk_o);

endmodule

// File: tb/adc_read_seq_tb_top.sv
module adc_conv_model #(
  parameter int PH_MIN   = 4,
  parameter int ACQ_MIN  = 175,
  parameter int CONV_MIN = 463,
  parameter int HI_MIN   = 8,
  parameter int LO_MIN   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnv,
  input  logic       sclk,
  input  logic [9:0] val,
  output logic       sdata,
  output int         rises,
  output logic       mode2,
  output int         checks,
  output int         fails
);
  logic cnv_q, sclk_q, conv_on;
  int hi_len, lo_len, npulse, conv_cnt, sh, sl, falls;
  logic [11:0] frame;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s converter-side timing: actual %0d expected at least %0d", req, act, exp);
    end
  endtask

  initial begin
    checks = 0; fails = 0; rises = 0; mode2 = 1'b0; sdata = 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      cnv_q = 0; sclk_q = 0; conv_on = 0; hi_len = 0; lo_len = 0; npulse = 0;
      conv_cnt = 0; sh = 0; sl = 0; falls = 0; frame = '0;
      sdata <= 1'b0;
    end else begin
      if (cnv && !cnv_q) begin
        if (npulse == 1) chk(lo_len >= PH_MIN, "R3", lo_len, PH_MIN);
        npulse++;
        hi_len = 1;
      end else if (cnv) hi_len++;
      if (!cnv && cnv_q) begin
        if (hi_len < ACQ_MIN / 2) begin
          chk(hi_len >= PH_MIN, "R3", hi_len, PH_MIN);
        end else begin
          chk(hi_len >= ACQ_MIN, "R2", hi_len, ACQ_MIN);
          mode2 = (npulse == 2);
          npulse = 0; conv_on = 1; conv_cnt = 0; rises = 0; falls = 0;
          frame = {val, 2'b11};
          sdata <= 1'b0;
        end
        lo_len = 1;
      end else if (!cnv) lo_len++;
      if (conv_on) begin
        conv_cnt++;
        if (conv_cnt == CONV_MIN / 2) sdata <= frame[11];
      end
      if (sclk && !sclk_q) begin
        if (rises == 0) chk(conv_cnt >= CONV_MIN, "R4", conv_cnt, CONV_MIN);
        else chk(sl >= LO_MIN, "R5", sl, LO_MIN);
        rises++;
        sh = 1;
      end else if (sclk) sh++;
      if (!sclk && sclk_q) begin
        chk(sh >= HI_MIN, "R5", sh, HI_MIN);
        falls++;
        sdata <= (falls < 12) ? frame[11 - falls] : 1'b1;
        sl = 1;
      end else if (!sclk) sl++;
      cnv_q = cnv;
      sclk_q = sclk;
    end
  end
endmodule

module adc_read_seq_tb_top;
  typedef struct { logic mode; logic [9:0] val; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_mode = 1'b0;
  logic [9:0] val = '0;
  always #4 clk = ~clk;

  logic rdy_a, busy_a, cnv_a, sclk_a, sd_a, vld_a, twos_a;
  logic [9:0] data_a; logic [15:0] sext_a;
  logic rdy_b, busy_b, cnv_b, sclk_b, sd_b, vld_b, twos_b;
  logic [9:0] data_b; logic [15:0] sext_b;
  int rises_a, rises_b, mchk_a, mchk_b, mfail_a, mfail_b;
  logic m2_a, m2_b;

  adc_read_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_a), .req_mode(req_mode),
    .busy_o(busy_a), .cnv_o(cnv_a), .sclk_o(sclk_a), .sdata_i(sd_a), .res_valid(vld_a),
    .res_data(data_a), .res_twos(twos_a), .res_sext(sext_a));
  adc_read_seq #(.LONG_READ(1'b1)) dut16_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_b), .req_mode(req_mode),
    .busy_o(busy_b), .cnv_o(cnv_b), .sclk_o(sclk_b), .sdata_i(sd_b), .res_valid(vld_b),
    .res_data(data_b), .res_twos(twos_b), .res_sext(sext_b));

  // R10: minimums below are the ceilings of 30, 1400, 3700 and 63 ns at 8 ns
  adc_conv_model model_a (.clk(clk), .rst_n(rst_n), .cnv(cnv_a), .sclk(sclk_a), .val(val),
    .sdata(sd_a), .rises(rises_a), .mode2(m2_a), .checks(mchk_a), .fails(mfail_a));
  adc_conv_model model_b (.clk(clk), .rst_n(rst_n), .cnv(cnv_b), .sclk(sclk_b), .val(val),
    .sdata(sd_b), .rises(rises_b), .mode2(m2_b), .checks(mchk_b), .fails(mfail_b));

  int n_chk = 0, n_fail = 0, issued = 0, got_a = 0, got_b = 0, cycles = 0;
  bit finished = 0;
  exp_t q_a[$], q_b[$];
  logic pv_a = 0, pv_b = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic score(input exp_t e, input logic [9:0] d, input logic t, input logic [15:0] s,
                       input int r, input logic m2, input int nclk);
    logic [15:0] es;
    es = e.mode ? {{6{e.val[9]}}, e.val} : {6'b0, e.val};
    check(d == e.val, "R6", "result code", d, e.val);
    check(t == e.mode, "R7", "two's complement flag", t, e.mode);
    check(s == es, "R7", "extended result", s, es);
    check(r == nclk, "R5", "rising clock edges", r, nclk);
    check(m2 == e.mode, "R3", "strobe pattern mode", m2, e.mode);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (vld_a) begin
      check(!pv_a, "R9", "valid width", 2, 1);
      check(!cnv_a && !sclk_a, "R9", "lines quiet at result", {cnv_a, sclk_a}, 0);
      if (q_a.size() == 0) check(0, "R8", "unexpected result", 1, 0);
      else score(q_a.pop_front(), data_a, twos_a, sext_a, rises_a, m2_a, 12);
      got_a++;
    end
    if (vld_b) begin
      check(!pv_b, "R9", "valid width", 2, 1);
      if (q_b.size() == 0) check(0, "R8", "unexpected result", 1, 0);
      else score(q_b.pop_front(), data_b, twos_b, sext_b, rises_b, m2_b, 16);
      got_b++;
    end
    pv_a = vld_a; pv_b = vld_b;
  end

  task automatic conv(input logic mode, input logic [9:0] v, input bit poke);
    exp_t e;
    while (!(rdy_a && rdy_b)) @(negedge clk);
    check(!cnv_a && !sclk_a && !sclk_b && !busy_a, "R1", "idle lines", {cnv_a, sclk_a, sclk_b, busy_a}, 0);
    e.mode = mode; e.val = v;
    val = v; req_mode = mode; req_valid = 1'b1;
    q_a.push_back(e); q_b.push_back(e); issued++;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      check(!rdy_a && !rdy_b, "R8", "ready while busy", {rdy_a, rdy_b}, 0);
      req_mode = ~mode; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_chk + mchk_a + mchk_b, n_fail + mfail_a + mfail_b);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cnv_a && !cnv_b && !sclk_a && !sclk_b, "R1", "reset lines", {cnv_a, cnv_b, sclk_a, sclk_b}, 0);
    check(rdy_a && rdy_b && !busy_a && !vld_a, "R1", "reset handshake", {rdy_a, rdy_b, busy_a, vld_a}, 4'b1100);
    conv(1'b0, 10'h000, 0);
    conv(1'b0, 10'h3FF, 0);
    conv(1'b1, 10'h200, 0);
    conv(1'b1, 10'h1FF, 1);
    conv(1'b0, 10'h155, 1);
    conv(1'b1, 10'h2AA, 0);
    conv(1'b1, 10'h3FF, 0);
    conv(1'b0, 10'h001, 0);
    while (!(rdy_a && rdy_b) || q_a.size() != 0 || q_b.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(got_a == issued && got_b == issued, "R8", "result count", got_a + got_b, 2 * issued);
    check(!sclk_a && !sclk_b && !cnv_a, "R5", "clock idle low", {sclk_a, sclk_b, cnv_a}, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk + mchk_a + mchk_b, n_fail + mfail_a + mfail_b);
    $finish;
  end
endmodule